// File: doc/BRIEF.md
# Rotating ROM Address Former

This block keeps a 16-bit address word that a host can load and read back, and a shift-control word loaded by a separate write. Each write to the shift-control word rotates the address word once, left or right. The amount and direction come either from a fixed choice made by a 2-bit mode input or from a one-hot position code inside the control word that is being written. All movement is circular: bits that leave one end of the word come back in at the other end.

A 14-bit ROM address is formed continuously from the address word and some side inputs. The three top bits come from an external field. The low eight bits come from the address word. The three middle bits come either from the address word or from an alternate 3-bit input, chosen by a swap flag. The ROM that this address drives lies outside the block.

Top module: `rom_addr_rotator`

## Requirements
- R1: After reset, the address word and the control word both read as 0x0000, and rom_addr[7:0] and rom_addr[10:8] (with mid_swap=0) are zero.
- R2: A write with reg_sel=0 loads wr_data into the address word. A read with reg_sel=0 returns the address word as it was at the read edge, on rd_data one cycle later.
- R3: A write with reg_sel=1 stores wr_data as the control word. A read with reg_sel=1 returns it.
- R4: A control write with shift_mode=01 rotates the address word right by 4.
- R5: A control write with shift_mode=10 rotates the address word left by 4.
- R6: A control write with shift_mode=00 leaves the address word unchanged.
- R7: With shift_mode=11, the written control word selects a left rotation: bit 7 alone gives 3 places, bit 8 alone gives 2, and bit 9 alone gives 1 (for example 0x2DB5 becomes 0xB6D4 with bit 8).
- R8: With shift_mode=11, bit 10 alone gives no rotation, and a right rotation is selected by bit 11 alone (1 place), bit 12 alone (2 places) or bit 13 alone (3 places). For example, 0x2DB5 becomes 0x96DA with bit 11 and 0xA5B6 with bit 13.
- R9: With shift_mode=11, if none of bits 13..7 is set, or if more than one of them is set, the address word is not rotated. Bits outside 13..7 have no effect on the rotation.
- R10: The address word changes only on a write. Reads, idle cycles and changes of shift_mode without a write leave it unchanged.
- R11: rom_addr[13:11] equals rom_hi, and rom_addr[7:0] equals address word bits 7..0.
- R12: rom_addr[10:8] equals address word bits 10..8 when mid_swap=0, and equals alt_mid when mid_swap=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_sel | input | 1 | Selects the register: 0 = address word, 1 = control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered |
| shift_mode | input | 2 | Rotation mode select |
| rom_hi | input | 3 | Top three ROM address bits |
| alt_mid | input | 3 | Alternate middle ROM address bits |
| mid_swap | input | 1 | Uses alt_mid for the middle bits when set |
| rom_addr | output | 14 | Formed ROM address |

## Verification
The hardest case to reach from the ports is a control word that is not a clean one-hot code inside bits 13..7. This covers a zero code, two position bits set at once, and a single position bit mixed with set bits outside the decoded field. Each of these must leave the address word unmoved, or must rotate it only by the valid position bit. The vector table loads a fresh address word before every control write, so that each decode result is seen in isolation. Directed steps then confirm that changing shift_mode without a write, and reading repeatedly, leave the word unchanged.

// File: rtl/rom_addr_rotator.sv
module rom_addr_rotator #(
  parameter int DW = 16,
  parameter int AW = 14,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          reg_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    shift_mode,
  input  logic [HW-1:0] rom_hi,
  input  logic [HW-1:0] alt_mid,
  input  logic          mid_swap,
  output logic [AW-1:0] rom_addr
);
  localparam int POS_LO  = 7;
  localparam int POS_HI  = 13;
  localparam int POS_N   = POS_HI - POS_LO + 1;
  localparam int LOW_W   = AW - 2 * HW;
  localparam int FIXED_K = 4;

  logic [DW-1:0]    addr_q, ctrl_q;
  logic [POS_N-1:0] pos;
  int               lrot;
  logic [2*DW-1:0]  twice;
  logic [DW-1:0]    rotated;

  assign pos = wr_data[POS_HI:POS_LO];

  always_comb begin
    lrot = 0;
    unique case (shift_mode)
      2'b01: lrot = DW - FIXED_K;
      2'b10: lrot = FIXED_K;
      2'b11: begin
        if ($onehot(pos)) begin
          for (int i = 0; i < POS_N; i++)
            if (pos[i]) lrot = (i <= 3) ? (3 - i) : (DW - (i - 3));
        end
      end
      default: lrot = 0;
    endcase
  end

  assign twice   = {addr_q, addr_q} << lrot;
  assign rotated = twice[2*DW-1:DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      ctrl_q  <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= reg_sel ? ctrl_q : addr_q;
      if (wr_en) begin
        if (reg_sel) begin
          ctrl_q <= wr_data;
          addr_q <= rotated;
        end else begin
          addr_q <= wr_data;
        end
      end
    end
  end

  assign rom_addr = {rom_hi, (mid_swap ? alt_mid : addr_q[LOW_W+HW-1:LOW_W]), addr_q[LOW_W-1:0]};
endmodule

// File: rtl/rom_addr_rotator_chk.sv
module rom_addr_rotator_chk #(
  parameter int DW = 16,
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          reg_sel,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    shift_mode,
  input logic          mid_swap,
  input logic [AW-1:0] rom_addr,
  input logic [DW-1:0] addr_q
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (addr_q == $past(wr_data)));

  assert_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reg_sel) |=> (rd_data == $past(addr_q)));

  assert_rot_right4_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && shift_mode == 2'b01) |=>
      (addr_q == (($past(addr_q) >> 4) | ($past(addr_q) << (DW - 4)))));

  assert_rot_left4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && shift_mode == 2'b10) |=>
      (addr_q == (($past(addr_q) << 4) | ($past(addr_q) >> (DW - 4)))));

  assert_mode0_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && shift_mode == 2'b00) |=> $stable(addr_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_q));

  assert_low_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (rom_addr[7:0] == $past(wr_data[7:0])));

  assert_mid_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> (mid_swap || rom_addr[10:8] == $past(wr_data[10:8])));
endmodule

bind rom_addr_rotator rom_addr_rotator_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .rd_data(rd_data), .shift_mode(shift_mode),
  .mid_swap(mid_swap), .rom_addr(rom_addr), .addr_q(addr_q)
);

// File: tb/rom_addr_rotator_tb.sv
module rom_addr_rotator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  shift_mode = 2'b00;
  logic [2:0]  rom_hi = '0, alt_mid = '0;
  logic        mid_swap = 1'b0;
  logic [13:0] rom_addr;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rom_addr_rotator dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .shift_mode(shift_mode),
    .rom_hi(rom_hi), .alt_mid(alt_mid), .mid_swap(mid_swap), .rom_addr(rom_addr)
  );

  // {req, start, mode, ctrl, expected}
  localparam int NV = 16;
  localparam logic [57:0] VEC [NV] = '{
    {8'd7,  16'h2DB5, 2'b11, 16'h0100, 16'hB6D4},  // R7 left 2
    {8'd7,  16'h2DB5, 2'b11, 16'h0200, 16'h5B6A},  // R7 left 1
    {8'd7,  16'h2DB5, 2'b11, 16'h0080, 16'h6DA9},  // R7 left 3
    {8'd8,  16'h2DB5, 2'b11, 16'h0400, 16'h2DB5},  // R8 none
    {8'd8,  16'h2DB5, 2'b11, 16'h0800, 16'h96DA},  // R8 right 1
    {8'd8,  16'h2DB5, 2'b11, 16'h1000, 16'h4B6D},  // R8 right 2
    {8'd8,  16'h2DB5, 2'b11, 16'h2000, 16'hA5B6},  // R8 right 3
    {8'd8,  16'h8001, 2'b11, 16'h0800, 16'hC000},  // R8 wrap
    {8'd7,  16'h8001, 2'b11, 16'h0200, 16'h0003},  // R7 wrap
    {8'd4,  16'h2DB5, 2'b01, 16'h0000, 16'h52DB},  // R4
    {8'd5,  16'h2DB5, 2'b10, 16'h0000, 16'hDB52},  // R5
    {8'd6,  16'h2DB5, 2'b00, 16'h2000, 16'h2DB5},  // R6
    {8'd9,  16'h2DB5, 2'b11, 16'h0000, 16'h2DB5},  // R9 no bit
    {8'd9,  16'h2DB5, 2'b11, 16'h0300, 16'h2DB5},  // R9 two bits
    {8'd9,  16'h1234, 2'b11, 16'h0201, 16'h2468},  // R9 outside bit ignored
    {8'd9,  16'h1234, 2'b11, 16'hC07F, 16'h1234}   // R9 field empty, rest set
  };

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; reg_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; reg_sel = sel;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, v); chk("R1", v, 16'h0000);
    rd(1'b1, v); chk("R1", v, 16'h0000);
    chk("R1", {2'b00, rom_addr}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      shift_mode = VEC[i][33:32];
      wr(1'b0, VEC[i][49:34]);
      wr(1'b1, VEC[i][31:16]);
      rd(1'b0, v);
      chk($sformatf("R%0d vec%0d", VEC[i][57:50], i), v, VEC[i][15:0]);
    end

    // R2 plain load and readback
    wr(1'b0, 16'hA55A); rd(1'b0, v); chk("R2", v, 16'hA55A);
    // R3 control readback
    shift_mode = 2'b00;
    wr(1'b1, 16'h2000); rd(1'b1, v); chk("R3", v, 16'h2000);
    rd(1'b0, v); chk("R6", v, 16'hA55A);

    // R10 no drift without writes
    shift_mode = 2'b11;
    wr(1'b0, 16'h2DB5); wr(1'b1, 16'h1000);
    shift_mode = 2'b01;
    repeat (4) @(negedge clk);
    shift_mode = 2'b10;
    rd(1'b0, v); rd(1'b0, v); rd(1'b1, v);
    rd(1'b0, v); chk("R10", v, 16'h4B6D);

    // R11 / R12 address forming
    wr(1'b0, 16'h5A3C);
    rom_hi = 3'b101; alt_mid = 3'b110; mid_swap = 1'b0;
    @(negedge clk); chk("R11", {2'b00, rom_addr}, {2'b00, 3'b101, 3'b010, 8'h3C});
    mid_swap = 1'b1;
    @(negedge clk); chk("R12", {2'b00, rom_addr}, {2'b00, 3'b101, 3'b110, 8'h3C});
    mid_swap = 1'b0;
    @(negedge clk); chk("R12", {2'b00, rom_addr}, 16'h2A3C);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, v); chk("R1", v, 16'h0000);
    rd(1'b1, v); chk("R1", v, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule